// File: doc/BRIEF.md
# Tick Compare Timer

This block is a free-running cycle counter paired with a one-shot compare register. It produces a single-cycle pulse that software-interrupt logic uses to set the timer's interrupt flag. Both registers are one bit wider than the counter, and the top bit of each holds a control flag.

In the count word, the top bit is a read-protection flag. The block keeps this flag and reflects it on reads, but it never acts on it; privilege checking belongs to the core. In the compare word, the top bit disables the match.

A clock-enable input advances the counter. Software can write the count at any time and read it back. Each write to the compare word arms at most one match. If a compare value is written that the counter has already reached or passed, the match is not lost: it fires on the next tick.

Top module: `tick_compare_timer`

## Requirements
- R1: A count write loads bits 62:0 into the counter and bit 63 into the read-protection flag. In that cycle it takes priority over a tick.
- R2: The count read port returns the read-protection flag in bit 63 and the counter in bits 62:0, so bit 63 reads 1 exactly when the flag is set.
- R3: The counter advances by one on each clock where `tick_en` is high and no count write occurs, and holds otherwise. It wraps from 2^63-1 to 0 and leaves the flag unchanged.
- R4: Synchronous reset clears the counter and the compare value and sets both the read-protection flag and the disable flag. After reset the read port shows 0x8000_0000_0000_0000 and `match_pulse` is low.
- R5: A compare write takes bit 63 as the disable flag and bits 62:0 as the compare value. With the timer enabled, `match_pulse` is high during the cycle in which a tick has just brought the counter to the compare value.
- R6: A compare value of zero cancels any armed match and never produces a pulse.
- R7: While the disable flag is set, no pulse is produced, and writing it cancels any armed match.
- R8: If the written compare value is not above the counter value at the time of the write, the match fires on the first tick after the write.
- R9: Each compare write yields at most one pulse. After it fires, the counter revisiting the compare value, whether by ticking or by a count write, gives no further pulse until the next compare write.
- R10: A clock edge that carries a count write or a compare write never fires. `match_pulse` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | 64 | Count write word: flag in bit 63, value in bits 62:0 |
| cnt_rd_data | output | 64 | Count read word |
| lim_wr_en | input | 1 | Compare write strobe |
| lim_wr_data | input | 64 | Compare write word: disable in bit 63, value in bits 62:0 |
| match_pulse | output | 1 | One-cycle match pulse to the software-interrupt flag |

## Verification
The assertions assume that reset is applied for at least one clock before any property is evaluated. They also assume that every strobe and data input carries a known 0/1 value at each clock edge. The bench meets both conditions: it holds reset for several cycles and drives every input from defined values just after each falling edge. Random count and compare values are kept within a few hundred counts of each other, so armed matches, late compare values and collisions with write strobes all occur frequently. The full-width wrap and the coincident-write edges are reached by directed sequences.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  // What the compare state does on a given clock edge.
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_FIRE = 2'd2
  } cmp_act_t;

  // One-shot arming state of the compare unit.
  typedef struct packed {
    logic armed;  // a match is still owed for the current compare value
    logic late;   // compare value was already reached when written
  } arm_state_t;

endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [CNT_W:0]   wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             npt_q,
  output logic [CNT_W-1:0] cnt_inc
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  // Natural modulo-2^CNT_W wrap.
  assign cnt_inc = cnt_q + CNT_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      npt_q <= 1'b1;
    end else if (wr_en) begin
      cnt_q <= wr_data[CNT_W-1:0];
      npt_q <= wr_data[CNT_W];
    end else if (tick_en) begin
      cnt_q <= cnt_inc;
    end
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ({npt_q, cnt_q} == $past(wr_data)));                     // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !wr_en && cnt_q == CNT_TOP) |=> (cnt_q == '0));         // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_en) |=> ($stable(cnt_q) && $stable(npt_q)));       // R3

endmodule

// File: rtl/tcmp_compare.sv
module tcmp_compare
  import tcmp_pkg::*;
#(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cnt_wr_en,
  input  logic             lim_wr_en,
  input  logic [CNT_W:0]   lim_wr_data,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_inc,
  output logic             match_o
);

  logic [CNT_W-1:0] lim_q;
  logic             dis_q;
  arm_state_t       arm_q;
  cmp_act_t         act;

  logic [CNT_W-1:0] new_lim;
  logic             new_dis;
  logic             new_armed;
  logic             new_late;
  logic             hit;
  logic             fire;

  assign new_lim   = lim_wr_data[CNT_W-1:0];
  assign new_dis   = lim_wr_data[CNT_W];
  assign new_armed = (new_lim != '0) && !new_dis;
  // Compare value not ahead of the counter: owed on the very next tick.
  assign new_late  = (new_lim <= cnt_q);

  assign hit  = arm_q.late || (cnt_inc == lim_q);
  assign fire = arm_q.armed && tick_en && !cnt_wr_en && !lim_wr_en && hit;

  always_comb begin
    if (lim_wr_en)  act = ACT_LOAD;
    else if (fire)  act = ACT_FIRE;
    else            act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q   <= '0;
      dis_q   <= 1'b1;
      arm_q   <= '0;
      match_o <= 1'b0;
    end else begin
      match_o <= fire;
      unique case (act)
        ACT_LOAD: begin
          lim_q       <= new_lim;
          dis_q       <= new_dis;
          arm_q.armed <= new_armed;
          arm_q.late  <= new_armed && new_late;
        end
        ACT_FIRE: begin
          arm_q <= '0;
        end
        default: begin
          arm_q <= arm_q;
        end
      endcase
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dis_q && !lim_wr_en) |=> !match_o);                                 // R7
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((lim_q == '0) && !lim_wr_en) |=> !match_o);                         // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);                                               // R10
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(tick_en && !cnt_wr_en && !lim_wr_en));             // R10
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    match_o |-> !arm_q.armed);                                           // R9

endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cnt_wr_en,
  input  logic [WORD_W-1:0] cnt_wr_data,
  output logic [WORD_W-1:0] cnt_rd_data,
  input  logic              lim_wr_en,
  input  logic [WORD_W-1:0] lim_wr_data,
  output logic              match_pulse
);

  localparam int CNT_W = WORD_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             npt_q;

  tcmp_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (cnt_wr_en),
    .wr_data (cnt_wr_data),
    .cnt_q   (cnt_q),
    .npt_q   (npt_q),
    .cnt_inc (cnt_inc)
  );

  tcmp_compare #(.CNT_W(CNT_W)) u_compare (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .cnt_wr_en   (cnt_wr_en),
    .lim_wr_en   (lim_wr_en),
    .lim_wr_data (lim_wr_data),
    .cnt_q       (cnt_q),
    .cnt_inc     (cnt_inc),
    .match_o     (match_pulse)
  );

  // The flag occupies the bit above the counter, so forcing it is a concatenation.
  assign cnt_rd_data = {npt_q, cnt_q};

  AST_RD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr_en && cnt_wr_data[CNT_W]) |=> cnt_rd_data[CNT_W]);          // R2

endmodule

// File: tb/tick_compare_timer_tb.sv
`timescale 1ns/1ps
module tick_compare_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        cnt_wr_en = 1'b0;
  logic [63:0] cnt_wr_data = '0;
  logic        lim_wr_en = 1'b0;
  logic [63:0] lim_wr_data = '0;
  logic [63:0] cnt_rd_data;
  logic        match_pulse;

  always #2.5 clk = ~clk;

  tick_compare_timer #(.WORD_W(64)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_rd_data(cnt_rd_data),
    .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data), .match_pulse(match_pulse)
  );

  // Reference state, built from the requirements.
  logic [62:0] m_cnt, m_lim;
  logic        m_npt, m_dis, m_armed, m_late, m_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd();
    return {m_npt, m_cnt};
  endfunction

  task automatic check_outputs(string req);
    chk(cnt_rd_data === exp_rd(), req, cnt_rd_data, exp_rd());
    chk(match_pulse === m_pulse, req, {63'd0, match_pulse}, {63'd0, m_pulse});
  endtask

  task automatic model_reset();
    m_cnt = '0; m_npt = 1'b1; m_lim = '0; m_dis = 1'b1;
    m_armed = 1'b0; m_late = 1'b0; m_pulse = 1'b0;
  endtask

  // Called just after a falling edge: drive, advance the model, check at next falling edge.
  task automatic cyc(bit t, bit cw, logic [63:0] cwd, bit lw, logic [63:0] lwd, string req);
    logic [62:0] inc;
    bit fire;
    tick_en = t; cnt_wr_en = cw; cnt_wr_data = cwd; lim_wr_en = lw; lim_wr_data = lwd;
    inc  = m_cnt + 63'd1;
    fire = m_armed && t && !cw && !lw && (m_late || inc == m_lim);
    if (lw) begin
      m_armed = (lwd[62:0] != 0) && !lwd[63];
      m_late  = m_armed && (lwd[62:0] <= m_cnt);
      m_lim   = lwd[62:0];
      m_dis   = lwd[63];
    end else if (fire) begin
      m_armed = 1'b0;
      m_late  = 1'b0;
    end
    if (cw) begin
      m_cnt = cwd[62:0];
      m_npt = cwd[63];
    end else if (t) begin
      m_cnt = inc;
    end
    m_pulse = fire;
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic tick(int n, string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4: reset values
    check_outputs("R4");
    chk(cnt_rd_data === 64'h8000_0000_0000_0000, "R4", cnt_rd_data, 64'h8000_0000_0000_0000);

    // R1: count write beats a tick in the same cycle; R2: flag clear reads 0 in bit 63
    cyc(1'b1, 1'b1, 64'h0000_0000_0000_0010, 1'b0, '0, "R1");
    chk(cnt_rd_data === 64'h10, "R2", cnt_rd_data, 64'h10);
    tick(5, "R3");
    cyc(1'b0, 1'b0, '0, 1'b0, '0, "R3");
    chk(cnt_rd_data === 64'h15, "R3", cnt_rd_data, 64'h15);

    // R5: match when the counter ticks onto 0x20
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h20, "R5");
    tick(10, "R5");
    tick(1, "R5");
    chk(match_pulse === 1'b1 && cnt_rd_data === 64'h20, "R5", {63'd0, match_pulse}, 64'h1);
    tick(4, "R9");
    // R9: revisit the value by a count write, no second pulse
    cyc(1'b0, 1'b1, 64'h1E, 1'b0, '0, "R9");
    tick(4, "R9");

    // R7: disabled compare never fires
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h8000_0000_0000_0030, "R7");
    cyc(1'b0, 1'b1, 64'h2E, 1'b0, '0, "R7");
    tick(6, "R7");
    // R7: enabled then disabled before reaching it
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h38, "R7");
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h8000_0000_0000_0038, "R7");
    tick(6, "R7");

    // R6: zero compare cancels an armed match
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h40, "R6");
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h0, "R6");
    tick(12, "R6");

    // R8: compare value already behind the counter fires on the next tick
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h10, "R8");
    cyc(1'b0, 1'b0, '0, 1'b0, '0, "R8");
    tick(1, "R8");
    chk(match_pulse === 1'b1, "R8", {63'd0, match_pulse}, 64'h1);
    tick(2, "R8");
    // R8: compare equal to current count counts as behind
    cyc(1'b0, 1'b0, '0, 1'b1, {1'b0, m_cnt}, "R8");
    tick(1, "R8");
    chk(match_pulse === 1'b1, "R8", {63'd0, match_pulse}, 64'h1);

    // R2/R3: wrap from all ones with flag set
    cyc(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0, "R2");
    chk(cnt_rd_data === 64'hFFFF_FFFF_FFFF_FFFF, "R2", cnt_rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
    tick(1, "R3");
    chk(cnt_rd_data === 64'h8000_0000_0000_0000, "R3", cnt_rd_data, 64'h8000_0000_0000_0000);

    // R10: count write on the matching tick suppresses it; next real tick fires
    cyc(1'b0, 1'b1, 64'h100, 1'b0, '0, "R10");
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h101, "R10");
    cyc(1'b1, 1'b1, 64'h100, 1'b0, '0, "R10");
    chk(match_pulse === 1'b0, "R10", {63'd0, match_pulse}, 64'h0);
    tick(1, "R10");
    chk(match_pulse === 1'b1, "R10", {63'd0, match_pulse}, 64'h1);
    // R10: compare write on the tick that reaches its value does not fire
    cyc(1'b1, 1'b0, '0, 1'b1, {1'b0, m_cnt + 63'd1}, "R10");
    tick(3, "R10");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit t, cw, lw;
      logic [63:0] cwd, lwd;
      t   = ($urandom % 4) != 0;
      cw  = ($urandom % 16) == 0;
      lw  = ($urandom % 10) == 0;
      cwd = {1'($urandom % 2), 55'd0, 8'($urandom % 256)};
      lwd = {1'(($urandom % 5) == 0), 54'd0,
             (($urandom % 8) == 0) ? 9'd0 : 9'($urandom % 300)};
      cyc(t, cw, cwd, lw, lwd, "R5/R3");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule